// File: doc/BRIEF.md
# Indirect Line Configuration Register Block

This block is the host-side register file for an eight-channel line interface. A byte-wide read/write port with an 8-bit address reaches four registers: a channel pointer, a shared data window, a transmit output-disable mask and an alarm status register. Per-channel line settings live in a small storage bank. The host reaches that bank only through the pointer and the window. The host writes the channel number into the pointer, then reads or writes that channel's entry through the window.

Every channel's stored setting goes straight to the datapath as a flat vector. A per-channel decode flags the 75-ohm line code. The output-disable mask turns each channel's transmit driver enable off. The alarm status register latches per-channel all-ones alarm detects, drives an active-high interrupt, and clears on a host read of its address.

Reads are combinational from the address. Writes and read side effects take effect at the rising clock edge at which the enable is sampled. The asynchronous active-low reset is released synchronously through a two-stage synchronizer inside the block.

Top module: `lcfg_regs`

## Requirements
- R1: After reset the pointer, every channel entry, the output-disable mask and the alarm status all read 00h. All transmit driver enables are high, the interrupt is low and the configuration outputs are zero.
- R2: Address 10h holds the channel pointer in bits 2:0. Bits 7:3 read back as zero whatever was written.
- R3: A write to 11h changes only the entry selected by the pointer value held at that write. Every other entry keeps its value.
- R4: A read of 11h returns the entry of the channel in the pointer. A read in the cycle after a pointer write returns the newly selected channel's entry.
- R5: An entry stores a 4-bit line code in bits 3:0 and a receive-matching select in bit 4 (1 = internal). Bits 7:5 read as zero. Channel n's entry appears on `chan_cfg[5n+4:5n]` in the same bit order.
- R6: `chan_is_75[n]` is high exactly when channel n's line code is 1000 (75-ohm E1). Code 0000 (120-ohm E1) and every other code leave it low.
- R7: Address 12h is a read/write mask. Bit n set drives `tx_drv_en[n]` low (driver in high impedance), one clock after the write.
- R8: An alarm status bit at 13h is set at every clock edge where its detect input is high.
- R9: A read of 13h returns the current status. At that read's clock edge, a status bit clears only if its detect input is low at that edge.
- R10: `irq` is high while any alarm status bit is set. It rises one clock after a detect input goes high.
- R11: Reads of unmapped addresses return 00h. Writes to unmapped addresses, and writes to the read-only 13h, change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register address |
| reg_wr_en | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata | input | 8 | Write data |
| reg_rd_en | input | 1 | Read strobe; its side effect applies at the rising edge |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| alarm_det | input | 8 | Per-channel all-ones alarm detect |
| tx_drv_en | output | 8 | Per-channel transmit driver enable, high = driving |
| chan_cfg | output | 40 | Five configuration bits per channel |
| chan_is_75 | output | 8 | Per-channel 75-ohm line code flag |
| irq | output | 1 | Alarm interrupt, active high |

## Verification
Each register output and configuration vector is due one clock after the edge that samples a write. Read data is due in the same cycle as the address, so the bench drives every input on the falling edge and samples one time unit later, before the next rising edge. An alarm bit and `irq` are due one edge after a detect rises. A clear-on-read is seen on a read issued in the cycle after the clearing read. The bench checks the window right after a pointer change and the case where a detect is still high during the clearing read.

// File: rtl/lcfg_pkg.sv
package lcfg_pkg;
  localparam int unsigned REG_DW = 8;
  localparam int unsigned REG_AW = 8;

  localparam logic [REG_AW-1:0] ADDR_PTR = 8'h10;
  localparam logic [REG_AW-1:0] ADDR_WIN = 8'h11;
  localparam logic [REG_AW-1:0] ADDR_ODIS = 8'h12;
  localparam logic [REG_AW-1:0] ADDR_ALM = 8'h13;

  localparam int unsigned CODE_W = 4;
  localparam logic [CODE_W-1:0] CODE_E1_120 = 4'b0000;
  localparam logic [CODE_W-1:0] CODE_E1_75 = 4'b1000;

  typedef struct packed {
    logic              rx_int_match;
    logic [CODE_W-1:0] line_code;
  } line_cfg_t;

  localparam int unsigned CFG_W = $bits(line_cfg_t);
endpackage

// File: rtl/lcfg_rst_sync.sv
module lcfg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/lcfg_decode.sv
module lcfg_decode
  import lcfg_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  localparam int unsigned PTR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [PTR_W-1:0]  ptr_q,
  input  line_cfg_t         win_cfg,
  input  logic [NUM_CH-1:0] odis_q,
  input  logic [NUM_CH-1:0] alm_q,
  output logic              wr_ptr,
  output logic              wr_win,
  output logic              wr_odis,
  output logic              alm_rd_clr,
  output logic [REG_DW-1:0] rdata
);
  logic hit_ptr, hit_win, hit_odis, hit_alm, hit_any;

  always_comb begin
    hit_ptr  = (addr == ADDR_PTR);
    hit_win  = (addr == ADDR_WIN);
    hit_odis = (addr == ADDR_ODIS);
    hit_alm  = (addr == ADDR_ALM);
    hit_any  = hit_ptr | hit_win | hit_odis | hit_alm;
  end

  // Write strobes; the alarm register is read-only so it has none.
  always_comb begin
    wr_ptr     = wr_en & hit_ptr;
    wr_win     = wr_en & hit_win;
    wr_odis    = wr_en & hit_odis;
    alm_rd_clr = rd_en & hit_alm;
  end

  always_comb begin
    rdata = '0;
    unique case (1'b1)
      hit_ptr:  rdata = REG_DW'(ptr_q);
      hit_win:  rdata = REG_DW'(win_cfg);
      hit_odis: rdata = REG_DW'(odis_q);
      hit_alm:  rdata = REG_DW'(alm_q);
      default:  rdata = '0;
    endcase
  end

  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_any |-> (rdata == '0));

  // R2
  ptr_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ptr |-> (rdata[REG_DW-1:PTR_W] == '0));

  // R5
  win_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_win |-> (rdata[REG_DW-1:CFG_W] == '0));
endmodule

// File: rtl/lcfg_cfg_bank.sv
module lcfg_cfg_bank
  import lcfg_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  localparam int unsigned PTR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [PTR_W-1:0]        sel,
  input  line_cfg_t               wr_cfg,
  output line_cfg_t               sel_cfg,
  output logic [NUM_CH*CFG_W-1:0] cfg_flat,
  output logic [NUM_CH-1:0]       is_75
);
  line_cfg_t entry_q [NUM_CH];
  line_cfg_t entry_d [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_entry
    logic ld;

    always_comb begin
      ld         = wr_en && (sel == PTR_W'(i));
      entry_d[i] = ld ? wr_cfg : entry_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) entry_q[i] <= '0;
      else        entry_q[i] <= entry_d[i];
    end

    assign cfg_flat[i*CFG_W +: CFG_W] = entry_q[i];
    assign is_75[i] = (entry_q[i].line_code == CODE_E1_75);

    // R3
    other_entry_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (sel == PTR_W'(i))) |=> $stable(entry_q[i]));
  end

  always_comb begin
    sel_cfg = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (sel == PTR_W'(k)) sel_cfg = entry_q[k];
    end
  end
endmodule

// File: rtl/lcfg_alarm_reg.sv
module lcfg_alarm_reg #(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] det,
  input  logic              rd_clr,
  output logic [NUM_CH-1:0] status_q,
  output logic              irq
);
  logic [NUM_CH-1:0] status_d;

  always_comb begin
    status_d = (rd_clr ? '0 : status_q) | det;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assign irq = |status_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R8
    alarm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      det[i] |=> status_q[i]);
    // R9
    alarm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q[i] && !rd_clr) |=> status_q[i]);
    // R9
    alarm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !det[i]) |=> !status_q[i]);
  end
endmodule

// File: rtl/lcfg_regs.sv
module lcfg_regs
  import lcfg_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  localparam int unsigned PTR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [REG_AW-1:0]       reg_addr,
  input  logic                    reg_wr_en,
  input  logic [REG_DW-1:0]       reg_wdata,
  input  logic                    reg_rd_en,
  output logic [REG_DW-1:0]       reg_rdata,
  input  logic [NUM_CH-1:0]       alarm_det,
  output logic [NUM_CH-1:0]       tx_drv_en,
  output logic [NUM_CH*CFG_W-1:0] chan_cfg,
  output logic [NUM_CH-1:0]       chan_is_75,
  output logic                    irq
);
  logic              srst_n;
  logic              wr_ptr, wr_win, wr_odis, alm_rd_clr;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic [NUM_CH-1:0] odis_q, odis_d;
  logic [NUM_CH-1:0] alm_q;
  line_cfg_t         win_cfg;
  line_cfg_t         wr_cfg;

  lcfg_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  lcfg_decode #(.NUM_CH(NUM_CH)) u_decode (
    .clk        (clk),
    .rst_n      (srst_n),
    .addr       (reg_addr),
    .wr_en      (reg_wr_en),
    .rd_en      (reg_rd_en),
    .ptr_q      (ptr_q),
    .win_cfg    (win_cfg),
    .odis_q     (odis_q),
    .alm_q      (alm_q),
    .wr_ptr     (wr_ptr),
    .wr_win     (wr_win),
    .wr_odis    (wr_odis),
    .alm_rd_clr (alm_rd_clr),
    .rdata      (reg_rdata)
  );

  // Pointer and output-disable mask: next-state then register.
  always_comb begin
    ptr_d  = wr_ptr  ? reg_wdata[PTR_W-1:0]  : ptr_q;
    odis_d = wr_odis ? reg_wdata[NUM_CH-1:0] : odis_q;
    wr_cfg = reg_wdata[CFG_W-1:0];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ptr_q  <= '0;
      odis_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      odis_q <= odis_d;
    end
  end

  assign tx_drv_en = ~odis_q;

  lcfg_cfg_bank #(.NUM_CH(NUM_CH)) u_cfg_bank (
    .clk      (clk),
    .rst_n    (srst_n),
    .wr_en    (wr_win),
    .sel      (ptr_q),
    .wr_cfg   (wr_cfg),
    .sel_cfg  (win_cfg),
    .cfg_flat (chan_cfg),
    .is_75    (chan_is_75)
  );

  lcfg_alarm_reg #(.NUM_CH(NUM_CH)) u_alarm (
    .clk      (clk),
    .rst_n    (srst_n),
    .det      (alarm_det),
    .rd_clr   (alm_rd_clr),
    .status_q (alm_q),
    .irq      (irq)
  );

  // R7
  odis_drive_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (reg_wr_en && reg_addr == ADDR_ODIS) |=> (tx_drv_en == ~$past(reg_wdata[NUM_CH-1:0])));

  // R10
  irq_rise_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (|alarm_det) |=> irq);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !srst_n |-> (!irq && tx_drv_en == '1 && chan_cfg == '0));
endmodule

// File: tb/lcfg_regs_tb.sv
module lcfg_regs_tb;
  localparam time CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  reg_addr;
  logic        reg_wr_en;
  logic [7:0]  reg_wdata;
  logic        reg_rd_en;
  logic [7:0]  reg_rdata;
  logic [7:0]  alarm_det;
  logic [7:0]  tx_drv_en;
  logic [39:0] chan_cfg;
  logic [7:0]  chan_is_75;
  logic        irq;

  int vec_cnt = 0;
  int err_cnt = 0;
  logic [4:0] exp_cfg [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  lcfg_regs u_dut (
    .clk (clk), .rst_n (rst_n), .reg_addr (reg_addr), .reg_wr_en (reg_wr_en),
    .reg_wdata (reg_wdata), .reg_rd_en (reg_rd_en), .reg_rdata (reg_rdata),
    .alarm_det (alarm_det), .tx_drv_en (tx_drv_en), .chan_cfg (chan_cfg),
    .chan_is_75 (chan_is_75), .irq (irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vec_cnt++;
    if (act !== exp) begin
      err_cnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_addr = 8'hFF;
  endtask

  task automatic rd(input logic [7:0] a, input string tag, input logic [7:0] exp);
    @(negedge clk);
    reg_addr = a; reg_rd_en = 1'b1;
    #1;
    chk(tag, reg_rdata, exp);
    @(negedge clk);
    reg_rd_en = 1'b0; reg_addr = 8'hFF;
  endtask

  function automatic logic [39:0] exp_flat();
    logic [39:0] f;
    for (int i = 0; i < 8; i++) f[i*5 +: 5] = exp_cfg[i];
    return f;
  endfunction

  task automatic t_reset();
    #1;
    chk("R1 reg_rdata", reg_rdata, 8'h00);
    for (int a = 8'h10; a <= 8'h13; a++) rd(8'(a), "R1 reset read", 8'h00);
    chk("R1 tx_drv_en", tx_drv_en, 8'hFF);
    chk("R1 irq", irq, 1'b0);
    chk("R1 chan_cfg", chan_cfg, 40'h0);
  endtask

  task automatic t_pointer();
    wr(8'h10, 8'hFD);
    rd(8'h10, "R2 ptr upper zero", 8'h05);
    wr(8'h10, 8'h00);
    rd(8'h10, "R2 ptr readback", 8'h00);
  endtask

  task automatic t_window();
    for (int c = 0; c < 8; c++) begin
      wr(8'h10, 8'(c));
      wr(8'h11, 8'hE0 | 8'((c * 3) & 5'h1F));
      exp_cfg[c] = 5'((c * 3) & 5'h1F);
    end
    chk("R3 R5 chan_cfg after fill", chan_cfg, exp_flat());
    // pointer write directly followed by a window read
    for (int c = 7; c >= 0; c--) begin
      @(negedge clk);
      reg_addr = 8'h10; reg_wdata = 8'(c); reg_wr_en = 1'b1;
      @(negedge clk);
      reg_wr_en = 1'b0; reg_addr = 8'h11; reg_rd_en = 1'b1;
      #1;
      chk("R4 window after pointer change", reg_rdata, {3'b000, exp_cfg[c]});
      @(negedge clk);
      reg_rd_en = 1'b0; reg_addr = 8'hFF;
    end
    wr(8'h10, 8'h03);
    wr(8'h11, 8'h1F);
    exp_cfg[3] = 5'h1F;
    chk("R3 only selected entry", chan_cfg, exp_flat());
    rd(8'h11, "R5 reserved bits zero", 8'h1F);
  endtask

  task automatic t_code();
    wr(8'h10, 8'h02); wr(8'h11, 8'h08); exp_cfg[2] = 5'h08;
    wr(8'h10, 8'h06); wr(8'h11, 8'h18); exp_cfg[6] = 5'h18;
    wr(8'h10, 8'h04); wr(8'h11, 8'h00); exp_cfg[4] = 5'h00;
    wr(8'h10, 8'h03); wr(8'h11, 8'h09); exp_cfg[3] = 5'h09;
    begin
      logic [7:0] e = '0;
      for (int i = 0; i < 8; i++) e[i] = (exp_cfg[i][3:0] == 4'b1000);
      #1;
      chk("R6 chan_is_75", chan_is_75, e);
      chk("R5 chan_cfg field order", chan_cfg, exp_flat());
    end
  endtask

  task automatic t_odis();
    wr(8'h12, 8'hA5);
    chk("R7 tx_drv_en", tx_drv_en, 8'h5A);
    rd(8'h12, "R7 readback", 8'hA5);
    @(negedge clk);
    reg_addr = 8'h12; reg_wdata = 8'h01; reg_wr_en = 1'b1;
    @(posedge clk); #1;
    chk("R7 one clock after write", tx_drv_en, 8'hFE);
    @(negedge clk);
    reg_wr_en = 1'b0; reg_addr = 8'hFF;
    wr(8'h12, 8'h00);
    chk("R7 all driving", tx_drv_en, 8'hFF);
  endtask

  task automatic t_alarm();
    @(negedge clk);
    alarm_det = 8'h04;
    #1; chk("R10 irq before edge", irq, 1'b0);
    @(negedge clk); #1;
    chk("R10 irq after detect", irq, 1'b1);
    rd(8'h13, "R8 status set", 8'h04);
    rd(8'h13, "R9 held while detect high", 8'h04);
    @(negedge clk);
    alarm_det = 8'h00;
    rd(8'h13, "R9 read before clear", 8'h04);
    rd(8'h13, "R9 cleared", 8'h00);
    chk("R10 irq low", irq, 1'b0);
    // a detect arriving during the clearing read survives
    @(negedge clk); alarm_det = 8'h81;
    @(negedge clk); alarm_det = 8'h00;
    @(negedge clk);
    reg_addr = 8'h13; reg_rd_en = 1'b1; alarm_det = 8'h20;
    #1; chk("R8 two bits", reg_rdata, 8'h81);
    @(negedge clk);
    reg_rd_en = 1'b0; reg_addr = 8'hFF; alarm_det = 8'h00;
    rd(8'h13, "R9 new detect kept", 8'h20);
    rd(8'h13, "R9 final clear", 8'h00);
  endtask

  task automatic t_unmapped();
    wr(8'h10, 8'h01);
    wr(8'h00, 8'hFF); wr(8'h14, 8'hFF); wr(8'h0F, 8'hFF); wr(8'h13, 8'hFF);
    rd(8'h10, "R11 ptr untouched", 8'h01);
    rd(8'h11, "R11 entry untouched", {3'b000, exp_cfg[1]});
    rd(8'h12, "R11 mask untouched", 8'h00);
    rd(8'h13, "R11 alarm read-only", 8'h00);
    rd(8'h14, "R11 unmapped read", 8'h00);
    rd(8'hFF, "R11 unmapped read top", 8'h00);
    chk("R11 chan_cfg untouched", chan_cfg, exp_flat());
    chk("R11 irq untouched", irq, 1'b0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    err_cnt++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) exp_cfg[i] = '0;
    rst_n = 1'b0; reg_addr = 8'hFF; reg_wr_en = 1'b0; reg_wdata = '0;
    reg_rd_en = 1'b0; alarm_det = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_pointer();
    t_window();
    t_code();
    t_odis();
    t_alarm();
    t_unmapped();
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end
endmodule